// File: doc/BRIEF.md
# Block-Transfer Configuration Register Slave on a Two-Wire Serial Bus

This block is an I2C slave that holds six 8-bit configuration bytes. It presents all six bytes in parallel to the rest of the chip. The slave has no register pointer and every transfer begins at byte 0.

In a write transfer, the host sends the slave's write address and then two bytes that the slave acknowledges and throws away. The data bytes that follow fill the configuration bytes from index 0 upward. Each byte takes effect as soon as it is acknowledged. In a read transfer, the slave first returns the value 6, then the six bytes in index order, then 0xFF for any further byte the host asks for.

SCL and SDA are oversampled in the system clock domain. The slave only pulls SDA low; the release of the line and the pull-up are left to the pad.

Top module: `cfg_block_slave`

## Requirements
- R1: After reset, `cfg_flat` holds byte0 = 0xFF, byte1 = 0xC0, byte2 = byte3 = byte4 = 0xFF and byte5 = 0x06. Byte i sits at bits [8i+7:8i].
- R2: The slave acknowledges the address byte only when it is 0xD2 (write) or 0xD3 (read). For any other address it never pulls SDA low during that transfer.
- R3: In a write transfer, the first two bytes after the address are acknowledged and do not change `cfg_flat`.
- R4: The data bytes of a write go to byte 0, 1, 2 and onward, in that order. Each one is visible on `cfg_flat` once its acknowledge bit completes. A stop that comes after any complete byte keeps the bytes already written. A byte that is cut short by a stop is not stored.
- R5: Write data bytes beyond byte 5 are acknowledged and leave `cfg_flat` unchanged.
- R6: A read returns 0x06 first, then bytes 0 through 5, each sent MSB first, while the host acknowledges.
- R7: A read byte requested after byte 5 is 0xFF.
- R8: Once the host does not acknowledge a read byte, the slave leaves SDA released until the next start or stop.
- R9: A start in the middle of a transfer, including a repeated start, begins a new transfer. That transfer again starts at byte 0, or at the count byte for a read.
- R10: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low reset; loads the default bytes |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High when the slave pulls SDA low |
| cfg_flat | output | 48 | Six configuration bytes; byte i at [8i+7:8i] |

## Verification
The assertions assume a host that changes SDA only while SCL is low, except for start and stop. They also assume each SCL level lasts well beyond the three system clocks the synchronizer and edge detector need. The bench drives every SCL phase for 20 system clocks, moves SDA only in the low phase or for start and stop, and models the bus as a wired-AND of the host and `sda_oe`. Under these conditions, a slave drive change during SCL high can only come from a design fault.

// File: rtl/cfg_block_slave.sv
module cfg_block_slave #(
  parameter int NREG = 6,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter logic [8*NREG-1:0] RESET_VAL = 48'h06FFFFFFC0FF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_in,
  input  logic            sda_in,
  output logic            sda_oe,
  output logic [8*NREG-1:0] cfg_flat
);
  localparam int IW = $clog2(NREG + 3);
  localparam logic [IW-1:0] IDX_MAX = IW'(NREG + 2);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_RACK, S_WAIT} st_t;

  logic [2:0] scl_sy, sda_sy;
  logic scl_s, sda_s, scl_p, sda_p;
  logic start_c, stop_c, scl_rise, scl_fall;
  st_t st;
  logic [3:0] cnt;
  logic [7:0] sh, tx_byte;
  logic is_addr, rw, ackok;
  logic [IW-1:0] idx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_in};
      sda_sy <= {sda_sy[1:0], sda_in};
    end

  assign scl_s = scl_sy[1];
  assign scl_p = scl_sy[2];
  assign sda_s = sda_sy[1];
  assign sda_p = sda_sy[2];
  assign start_c  = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_c   = scl_s & scl_p & ~sda_p & sda_s;
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;

  always_comb begin
    tx_byte = 8'hFF;
    if (idx == '0) tx_byte = 8'(NREG);
    for (int i = 0; i < NREG; i++)
      if (idx == IW'(i + 1)) tx_byte = cfg_flat[8*i +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      sh <= '0;
      is_addr <= 1'b0;
      rw <= 1'b0;
      ackok <= 1'b0;
      idx <= '0;
      cfg_flat <= RESET_VAL;
    end else if (start_c) begin
      st <= S_RX;
      is_addr <= 1'b1;
      cnt <= '0;
      idx <= '0;
    end else if (stop_c) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_RX:
          if (scl_rise) begin
            sh <= {sh[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            if (is_addr) begin
              if (sh[7:1] == DEV_ADDR) begin
                st <= S_ACK;
                rw <= sh[0];
              end else st <= S_IDLE;
            end else begin
              st <= S_ACK;
              for (int i = 0; i < NREG; i++)
                if (idx == IW'(i + 2)) cfg_flat[8*i +: 8] <= sh;
              if (idx != IDX_MAX) idx <= idx + 1'b1;
            end
          end
        S_ACK:
          if (scl_fall) begin
            is_addr <= 1'b0;
            cnt <= '0;
            if (rw) begin
              st <= S_TX;
              sh <= tx_byte;
              if (idx != IDX_MAX) idx <= idx + 1'b1;
            end else st <= S_RX;
          end
        S_TX:
          if (scl_fall) begin
            if (cnt == 4'd7) st <= S_RACK;
            else begin
              sh <= {sh[6:0], 1'b1};
              cnt <= cnt + 4'd1;
            end
          end
        S_RACK:
          if (scl_rise) ackok <= ~sda_s;
          else if (scl_fall) begin
            if (ackok) begin
              st <= S_TX;
              sh <= tx_byte;
              cnt <= '0;
              if (idx != IDX_MAX) idx <= idx + 1'b1;
            end else st <= S_WAIT;
          end
        default: ;
      endcase
    end
  end

  assign sda_oe = (st == S_ACK) | ((st == S_TX) & ~sh[7]);

  // R10
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  // R8
  nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RACK && scl_fall && !ackok) |=> !sda_oe);

  // R2
  addr_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RX && is_addr && scl_fall && cnt == 4'd8 && sh[7:1] != DEV_ADDR) |=> !sda_oe);

  // R4
  cfg_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_flat) |-> ($past(st) == S_RX && !$past(is_addr)));

  // R5
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IDX_MAX);
endmodule

// File: tb/cfg_block_slave_bench.sv
module cfg_block_slave_bench;
  localparam int Q = 20;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [47:0] cfg_flat;
  wire sda_line = sda_m & ~sda_oe;
  int n_chk = 0, n_fail = 0, oe_viol = 0;
  logic prev_oe = 1'b0;
  logic [47:0] exp_cfg;

  // {expected ack, address byte}
  localparam logic [8:0] ADDR_VEC [6] = '{9'h1D2, 9'h1D3, 9'h0D0, 9'h052, 9'h0D4, 9'h053};

  always #5 clk = ~clk;

  cfg_block_slave u_cfg_block_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_oe(sda_oe), .cfg_flat(cfg_flat));

  always @(posedge clk) begin
    if (rst_n && scl_m && sda_oe !== prev_oe) oe_viol <= oe_viol + 1;
    prev_oe <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_q(); repeat (Q) @(negedge clk); endtask
  task automatic bus_start();
    sda_m = 1; wait_q(); scl_m = 1; wait_q(); sda_m = 0; wait_q(); scl_m = 0; wait_q();
  endtask
  task automatic bus_stop();
    sda_m = 0; wait_q(); scl_m = 1; wait_q(); sda_m = 1; wait_q();
  endtask
  task automatic send_bit(input logic b);
    sda_m = b; wait_q(); scl_m = 1; wait_q(); wait_q(); scl_m = 0; wait_q();
  endtask
  task automatic recv_bit(output logic b);
    sda_m = 1; wait_q(); scl_m = 1; wait_q(); b = sda_line; wait_q(); scl_m = 0; wait_q();
  endtask
  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = ~b;
  endtask
  task automatic recv_byte(input logic host_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); d[i] = b; end
    send_bit(~host_ack);
  endtask
  task automatic wr(input logic [7:0] d, input string req);
    logic a;
    send_byte(d, a);
    chk(a, req, {63'd0, a}, 64'd1);
  endtask

  initial begin
    logic a;
    logic [7:0] d;
    logic all_hi;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    exp_cfg = 48'h06FFFFFFC0FF;
    chk(cfg_flat == exp_cfg, "R1 reset defaults", cfg_flat, exp_cfg);

    // R2 address filter
    for (int v = 0; v < 6; v++) begin
      bus_start();
      send_byte(ADDR_VEC[v][7:0], a);
      chk(a == ADDR_VEC[v][8], "R2 address ack", {56'd0, ADDR_VEC[v][7:0]}, {63'd0, ADDR_VEC[v][8]});
      if (a && ADDR_VEC[v][0]) recv_byte(1'b0, d);
      bus_stop();
    end

    // R3 R4 full write
    bus_start();
    wr(8'hD2, "R3 addr");
    wr(8'h12, "R3 command ack");
    wr(8'h34, "R3 count ack");
    chk(cfg_flat == exp_cfg, "R3 ignored bytes", cfg_flat, exp_cfg);
    for (int i = 0; i < 6; i++) begin
      wr(8'hA1 + 8'(i) * 8'h11, "R4 data ack");
      exp_cfg[8*i +: 8] = 8'hA1 + 8'(i) * 8'h11;
      chk(cfg_flat == exp_cfg, "R4 byte committed at ack", cfg_flat, exp_cfg);
    end
    bus_stop();

    // R5 excess bytes
    bus_start();
    wr(8'hD2, "R5 addr"); wr(8'h00, "R5 cmd"); wr(8'h00, "R5 cnt");
    for (int i = 0; i < 6; i++) begin
      wr(8'h10 * 8'(i + 1), "R5 data");
      exp_cfg[8*i +: 8] = 8'h10 * 8'(i + 1);
    end
    wr(8'h00, "R5 extra byte ack");
    wr(8'h00, "R5 extra byte ack");
    bus_stop();
    chk(cfg_flat == exp_cfg, "R5 extra bytes dropped", cfg_flat, exp_cfg);

    // R9 partial write restarts at byte 0
    bus_start();
    wr(8'hD2, "R9 addr"); wr(8'h00, "R9 cmd"); wr(8'h00, "R9 cnt");
    wr(8'h11, "R9 data"); wr(8'h22, "R9 data");
    bus_stop();
    exp_cfg[7:0] = 8'h11; exp_cfg[15:8] = 8'h22;
    chk(cfg_flat == exp_cfg, "R9 new transfer at byte 0", cfg_flat, exp_cfg);

    // R4 truncated byte not stored
    bus_start();
    wr(8'hD2, "R4 addr"); wr(8'h00, "R4 cmd"); wr(8'h00, "R4 cnt");
    wr(8'h33, "R4 data");
    send_bit(1); send_bit(0); send_bit(1); send_bit(0);
    bus_stop();
    exp_cfg[7:0] = 8'h33;
    chk(cfg_flat == exp_cfg, "R4 truncated byte dropped", cfg_flat, exp_cfg);

    // R6 R7 read
    bus_start();
    wr(8'hD3, "R6 addr");
    recv_byte(1'b1, d);
    chk(d == 8'h06, "R6 count byte", {56'd0, d}, 64'h06);
    for (int i = 0; i < 6; i++) begin
      recv_byte(1'b1, d);
      chk(d == exp_cfg[8*i +: 8], "R6 read byte", {56'd0, d}, {56'd0, exp_cfg[8*i +: 8]});
    end
    recv_byte(1'b1, d);
    chk(d == 8'hFF, "R7 past end", {56'd0, d}, 64'hFF);
    recv_byte(1'b0, d);
    chk(d == 8'hFF, "R7 past end", {56'd0, d}, 64'hFF);
    bus_stop();

    // R8 host NACK releases SDA
    bus_start();
    wr(8'hD3, "R8 addr");
    recv_byte(1'b0, d);
    chk(d == 8'h06, "R8 count before nack", {56'd0, d}, 64'h06);
    all_hi = 1'b1;
    for (int i = 0; i < 9; i++) begin
      logic b;
      recv_bit(b);
      all_hi &= b;
    end
    chk(all_hi, "R8 SDA released after nack", {63'd0, all_hi}, 64'd1);
    bus_stop();

    // R9 repeated start
    bus_start();
    wr(8'hD2, "R9 addr"); wr(8'h00, "R9 cmd"); wr(8'h00, "R9 cnt");
    wr(8'h5A, "R9 data");
    exp_cfg[7:0] = 8'h5A;
    bus_start();
    wr(8'hD3, "R9 repeated start addr");
    recv_byte(1'b1, d);
    chk(d == 8'h06, "R9 count after repeated start", {56'd0, d}, 64'h06);
    recv_byte(1'b0, d);
    chk(d == 8'h5A, "R9 byte0 after repeated start", {56'd0, d}, 64'h5A);
    bus_stop();
    chk(cfg_flat == exp_cfg, "R9 final contents", cfg_flat, exp_cfg);

    chk(oe_viol == 0, "R10 drive changes only with SCL low", oe_viol, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule